// File: doc/BRIEF.md
# Ratio-Constrained Clock Divider Control Register

This block holds a 16-bit clock control word that sets six power-of-two clock divisions, all derived from one root clock: peripheral, display (LCD), CPU, DSP, traffic controller (the on-chip memory/bus controller) and DSP MMU. Each domain has a 2-bit exponent `e`, and its divide ratio is 2^e (1, 2, 4 or 8). The block has no frequency ceilings. It enforces only the ordering rules between the domain ratios.

When the word is written, a combinational sanitizer first rewrites the exponents so that they satisfy the ordering rules. The DSP MMU exponent is clamped into the range from the DSP exponent to the DSP exponent plus one. The traffic controller exponent is then raised until it is at least the CPU exponent and at least the clamped DSP MMU exponent. Finally, the LCD and peripheral exponents are each raised until they are at least the traffic controller exponent. The sanitized word is stored, and this stored word is what a read returns.

The stored setting does not drive the dividers at once. It becomes active only at the wrap of a shared 3-bit phase counter, the point where every divider is aligned. Because of this, no domain sees a shortened enable period. For each domain the block produces a one-cycle clock enable in the root clock domain.

Top module: `clk_ratio_ctl`

## Requirements
- R1: After reset, `rdData` is 0 and all six exponents are active at 0, so every bit of `domEn` is high in every cycle.
- R2: The word has these fields: peripheral [1:0], LCD [3:2], CPU [5:4], DSP [7:6], traffic controller [9:8], DSP MMU [11:10]. Bits [15:12] are stored exactly as written.
- R3: If the written DSP MMU exponent is below the DSP exponent, the stored DSP MMU exponent equals the DSP exponent.
- R4: If the written DSP MMU exponent exceeds the DSP exponent plus one, the stored DSP MMU exponent equals the DSP exponent plus one.
- R5: The stored traffic controller exponent is the maximum of three values: the written traffic controller exponent, the CPU exponent and the clamped DSP MMU exponent.
- R6: The stored LCD and peripheral exponents are each the maximum of their written value and the stored traffic controller exponent. A word that already obeys R3 to R6 is stored unchanged.
- R7: `rdData` shows the sanitized stored word from the cycle after the write edge.
- R8: A 3-bit phase counter is 0 in the first cycle after reset and increments by one each cycle. `domEn[d]` is high exactly when the phase modulo 2^e is 0, where `e` is the active exponent of domain `d`. The domains are indexed 0=peripheral, 1=LCD, 2=CPU, 3=DSP, 4=traffic controller, 5=DSP MMU.
- R9: A stored word becomes active at the clock edge where the phase goes from 7 to 0. Until that edge, the enables follow the previous setting.
- R10: A word written at the edge that ends phase 7 becomes active at the next wrap, eight cycles later, and not at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Root clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the control word |
| wrData | input | 16 | Raw control word to write |
| rdData | output | 16 | Sanitized stored control word |
| domEn | output | 6 | Per-domain clock enables, indexed as in R8 |

## Verification
`rdData` changes one edge after the write strobe is sampled. The bench drives inputs on the falling edge and reads back on the next falling edge, so each read sees exactly one register stage.

The enables depend on the phase and on the active exponents. The bench keeps its own phase count from reset and its own copy of the pending and active words, both updated on the same edges as the design. Each enable check compares against these copies at the falling edge.

Writes placed mid-period and exactly at phase 7 check the one-edge apply point. Cycle-by-cycle comparison across the following wrap shows that the old setting holds until the wrap and that the new one starts on the cycle after it.

// File: rtl/clkr_pkg.sv
package clkr_pkg;
  localparam int EXP_W = 2;
  localparam int N_DOM = 6;
  localparam int REG_W = 16;
  localparam int PH_W  = (1 << EXP_W) - 1;
  localparam int PASS_LSB = N_DOM * EXP_W;

  localparam int F_PER = 0;
  localparam int F_LCD = 1;
  localparam int F_CPU = 2;
  localparam int F_DSP = 3;
  localparam int F_TC  = 4;
  localparam int F_MMU = 5;

  typedef struct packed {
    logic            loadShadow;
    logic            applyActive;
    logic [PH_W-1:0] phase;
  } ctlStrobes_t;

  function automatic logic [EXP_W:0] getExp(input logic [REG_W-1:0] w, input int f);
    return {1'b0, w[f*EXP_W +: EXP_W]};
  endfunction

  function automatic logic [REG_W-1:0] sanitize(input logic [REG_W-1:0] raw);
    logic [EXP_W:0] per, lcd, cpu, dsp, tc, mmu;
    logic [REG_W-1:0] res;
    per = getExp(raw, F_PER);
    lcd = getExp(raw, F_LCD);
    cpu = getExp(raw, F_CPU);
    dsp = getExp(raw, F_DSP);
    tc  = getExp(raw, F_TC);
    mmu = getExp(raw, F_MMU);
    if (mmu < dsp) mmu = dsp;
    if (mmu > dsp + 1'b1) mmu = dsp + 1'b1;
    if (tc < cpu) tc = cpu;
    if (tc < mmu) tc = mmu;
    if (lcd < tc) lcd = tc;
    if (per < tc) per = tc;
    res = raw;
    res[F_PER*EXP_W +: EXP_W] = per[EXP_W-1:0];
    res[F_LCD*EXP_W +: EXP_W] = lcd[EXP_W-1:0];
    res[F_CPU*EXP_W +: EXP_W] = cpu[EXP_W-1:0];
    res[F_DSP*EXP_W +: EXP_W] = dsp[EXP_W-1:0];
    res[F_TC*EXP_W  +: EXP_W] = tc[EXP_W-1:0];
    res[F_MMU*EXP_W +: EXP_W] = mmu[EXP_W-1:0];
    return res;
  endfunction
endpackage

// File: rtl/clkr_ctrl.sv
module clkr_ctrl
  import clkr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  output ctlStrobes_t strb
);
  localparam logic [PH_W-1:0] PH_LAST = '1;

  logic [PH_W-1:0] phaseQ;
  logic            pendQ;
  logic            atWrap;

  assign atWrap = (phaseQ == PH_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ <= '0;
      pendQ  <= 1'b0;
    end else begin
      phaseQ <= phaseQ + 1'b1;
      if (wrEn)        pendQ <= 1'b1;
      else if (atWrap) pendQ <= 1'b0;
    end
  end

  always_comb begin
    strb.loadShadow  = wrEn;
    strb.applyActive = pendQ && atWrap;
    strb.phase       = phaseQ;
  end

  // R8: the phase wraps to zero after its last value
  a_r8_phase_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (phaseQ == PH_LAST) |=> (phaseQ == '0));

  // R9: a write leaves an update pending
  a_r9_write_pends: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> pendQ);

  // R10: a pending update does not survive a wrap with no new write
  a_r10_pend_clears: assert property (@(posedge clk) disable iff (!rstN)
    (atWrap && !wrEn) |=> !pendQ);
endmodule

// File: rtl/clkr_datapath.sv
module clkr_datapath
  import clkr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobes_t      strb,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  output logic [N_DOM-1:0] domEn
);
  logic [REG_W-1:0] shadowQ;
  logic [REG_W-1:0] activeQ;
  logic [REG_W-1:0] cleanWord;

  assign cleanWord = sanitize(wrData);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowQ <= '0;
      activeQ <= '0;
    end else begin
      if (strb.loadShadow)  shadowQ <= cleanWord;
      if (strb.applyActive) activeQ <= shadowQ;
    end
  end

  assign rdData = shadowQ;

  for (genvar g = 0; g < N_DOM; g++) begin : g_dom
    logic [EXP_W-1:0] expV;
    logic [PH_W-1:0]  phMask;
    assign expV     = activeQ[g*EXP_W +: EXP_W];
    assign phMask   = PH_W'((1 << expV) - 1);
    assign domEn[g] = ((strb.phase & phMask) == '0);
  end

  // R2: the pass-through bits follow the written word
  a_r2_pass_bits: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadShadow |=> (shadowQ[REG_W-1:PASS_LSB] == $past(wrData[REG_W-1:PASS_LSB])));

  // R3 and R4: the stored DSP MMU exponent lies between dsp and dsp+1
  a_r3_mmu_floor: assert property (@(posedge clk) disable iff (!rstN)
    getExp(shadowQ, F_MMU) >= getExp(shadowQ, F_DSP));
  a_r4_mmu_ceiling: assert property (@(posedge clk) disable iff (!rstN)
    getExp(shadowQ, F_MMU) <= getExp(shadowQ, F_DSP) + 1'b1);

  // R5: the traffic controller is no faster than the CPU or the DSP MMU
  a_r5_tc_order: assert property (@(posedge clk) disable iff (!rstN)
    (getExp(shadowQ, F_TC) >= getExp(shadowQ, F_CPU)) &&
    (getExp(shadowQ, F_TC) >= getExp(shadowQ, F_MMU)));

  // R6: LCD and peripheral are no faster than the traffic controller
  a_r6_slow_order: assert property (@(posedge clk) disable iff (!rstN)
    (getExp(shadowQ, F_LCD) >= getExp(shadowQ, F_TC)) &&
    (getExp(shadowQ, F_PER) >= getExp(shadowQ, F_TC)));

  // R8: every domain is enabled at phase zero
  a_r8_align_zero: assert property (@(posedge clk) disable iff (!rstN)
    (strb.phase == '0) |-> (&domEn));

  // R9: the active setting changes only on the wrap into phase zero
  a_r9_active_hold: assert property (@(posedge clk) disable iff (!rstN)
    (strb.phase != '0) |-> $stable(activeQ));
endmodule

// File: rtl/clk_ratio_ctl.sv
module clk_ratio_ctl
  import clkr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  output logic [N_DOM-1:0] domEn
);
  ctlStrobes_t strb;

  clkr_ctrl ctrl_i (
    .clk  (clk),
    .rstN (rstN),
    .wrEn (wrEn),
    .strb (strb)
  );

  clkr_datapath dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrData (wrData),
    .rdData (rdData),
    .domEn  (domEn)
  );
endmodule

// File: tb/clk_ratio_ctl_tb_top.sv
`timescale 1ns/1ps
module clk_ratio_ctl_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic [5:0]  domEn;

  int nChk = 0;
  int nBad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  clk_ratio_ctl dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .domEn(domEn)
  );

  // bench-side copies of phase, pending and active words
  logic [2:0]  ph;
  logic        pendM;
  logic [15:0] shdM, actM, expNext;

  always @(posedge clk) begin
    if (!rstN) begin
      ph <= 3'd0; pendM <= 1'b0; shdM <= '0; actM <= '0;
    end else begin
      ph <= ph + 3'd1;
      if (ph == 3'd7 && pendM) actM <= shdM;
      if (wrEn) begin
        pendM <= 1'b1; shdM <= expNext;
      end else if (ph == 3'd7) pendM <= 1'b0;
    end
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] expEn(input logic [15:0] w, input logic [2:0] p);
    logic [5:0] r;
    for (int d = 0; d < 6; d++) begin
      int e;
      e = int'(w[d*2 +: 2]);
      r[d] = ((int'(p) % (1 << e)) == 0);
    end
    return r;
  endfunction

  task automatic checkEnCycles(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(req, {10'd0, domEn}, {10'd0, expEn(actM, ph)});
    end
  endtask

  task automatic doWrite(input logic [15:0] raw, input logic [15:0] exp);
    @(negedge clk);
    wrEn = 1'b1; wrData = raw; expNext = exp;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitPhase(input logic [2:0] p);
    do @(negedge clk); while (ph != p);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 rdData", rdData, 16'h0000);
    checkEnCycles("R1 R8 enables", 8);
  endtask

  task automatic t_write(input string req, input logic [15:0] raw, input logic [15:0] exp);
    doWrite(raw, exp);
    check(req, rdData, exp);
  endtask

  task automatic t_sanitize;
    t_write("R2 R7 pass bits", 16'hA000, 16'hA000);
    t_write("R3 R5 R6 mmu floor", 16'h0080, 16'h0A8A);
    t_write("R4 R5 R6 mmu ceiling", 16'h0C00, 16'h0505);
    t_write("R5 R6 cpu raises tc", 16'h5130, 16'h533F);
    t_write("R6 legal unchanged", 16'h0A5F, 16'h0A5F);
  endtask

  task automatic t_divide;
    waitPhase(3'd0);
    waitPhase(3'd0);
    check("R8 active word", actM, 16'h0A5F);
    checkEnCycles("R8 divide pattern", 16);
  endtask

  task automatic t_midwrite;
    waitPhase(3'd2);
    wrEn = 1'b1; wrData = 16'h0000; expNext = 16'h0000;
    @(negedge clk);
    wrEn = 1'b0;
    check("R7 read before apply", rdData, 16'h0000);
    @(negedge clk);
    check("R9 per held at old ratio", {15'd0, domEn[0]}, 16'd0);
    checkEnCycles("R9 old then new", 10);
    check("R9 applied", {10'd0, domEn}, 16'h003F);
  endtask

  task automatic t_wrapwrite;
    waitPhase(3'd7);
    wrEn = 1'b1; wrData = 16'h0A5F; expNext = 16'h0A5F;
    @(negedge clk);
    wrEn = 1'b0;
    @(negedge clk);
    check("R10 not applied at same wrap", {15'd0, domEn[0]}, 16'd1);
    checkEnCycles("R10 window", 14);
    waitPhase(3'd1);
    check("R10 applied next wrap", {15'd0, domEn[0]}, 16'd0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    expNext = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_sanitize();
    t_divide();
    t_midwrite();
    t_wrapwrite();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule